// File: doc/BRIEF.md
# External Asynchronous Memory Access Sequencer

This block produces the control timing for a single read or write to an external asynchronous memory device. A requester presents a request with a direction and an address. When the block is idle and enabled, it takes the request and latches the address and direction. It then drives a read or write strobe for a programmed number of bus clock cycles. If acknowledge handshaking is on, the strobe is stretched for as long as the external device holds its acknowledge input low. After a write, the address can stay on the bus for a few extra cycles. Every access ends with a single-cycle completion pulse.

The wait-state field is 5 bits wide and uses a compact encoding: the values 2 to 31 give that many strobe cycles, 1 gives a single cycle for slow clocks, and 0 stands for 32 cycles. The hold field is 3 bits wide and gives its binary value as the number of extra cycles, and it applies to writes only. Configuration inputs are expected to stay stable while an access is in flight.

Top module: `extmem_seq`

## Requirements
- R1: While `cfgEnable` is 0, no access is started: `reqReady`, `rdStrobe`, `wrStrobe`, `dataEnable` and `addrValid` all stay 0 whatever `reqValid` does.
- R2: A request is taken only at a rising edge where the block is idle, `cfgEnable` is 1 and `reqValid` is 1, and `reqReady` is 1 exactly in that idle-and-enabled condition. `busAddr` and the strobe direction then equal the address and `reqWrite` value present at that edge for the whole access, and requests raised mid-access are ignored.
- R3: With `cfgWaitStates` from 2 to 31, the strobe (`rdStrobe` for `reqWrite`=0, `wrStrobe` for `reqWrite`=1) is high for exactly that many cycles, starting the cycle after acceptance, when acknowledge extension does not apply.
- R4: `cfgWaitStates` = 0 gives a strobe of 32 cycles.
- R5: `cfgWaitStates` = 1 gives a strobe of exactly one cycle.
- R6: With `cfgAckEnable`=1, `ackIn` is first sampled at the edge that ends the last programmed strobe cycle. Each edge at which it is sampled low adds one more strobe cycle. With `cfgAckEnable`=0, `ackIn` has no effect on timing.
- R7: After a write strobe, `addrValid` and `dataEnable` stay high with both strobes low for `cfgHoldCycles` cycles (its binary value, 0 to 7).
- R8: A read gets no hold cycles: the completion pulse comes in the cycle right after the last read strobe cycle, whatever `cfgHoldCycles` is.
- R9: `donePulse` is high for exactly one cycle, in the cycle directly after the last strobe or hold cycle, with `addrValid` low. The block is idle again in the next cycle.
- R10: `rdStrobe` and `wrStrobe` are never high together, and `dataEnable` is high only during write accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgEnable | input | 1 | Block enable |
| cfgWaitStates | input | 5 | Strobe length code (0 means 32) |
| cfgAckEnable | input | 1 | Enable acknowledge extension |
| cfgHoldCycles | input | 3 | Post-write address hold length |
| reqValid | input | 1 | Access request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Access address |
| ackIn | input | 1 | External acknowledge, low extends the strobe |
| reqReady | output | 1 | Block idle and enabled, request would be taken |
| busAddr | output | ADDR_W | Latched access address |
| addrValid | output | 1 | Address driven during strobe and hold |
| rdStrobe | output | 1 | Read strobe, active high |
| wrStrobe | output | 1 | Write strobe, active high |
| dataEnable | output | 1 | Write data driver enable |
| donePulse | output | 1 | One-cycle completion pulse |

## Verification
The assertions take for granted that `cfgWaitStates`, `cfgAckEnable` and `cfgHoldCycles` do not change between acceptance and the completion pulse. The strobe-length and acknowledge checks compare against the current configuration rather than a latched copy. The stimulus changes configuration only at a falling edge while the block is idle, and it drives `ackIn` high by the edge that ends the intended last strobe cycle. Mid-access request activity is limited to `reqValid`, `reqAddr` and `reqWrite`, which the design has to ignore.

// File: rtl/extmem_pkg.sv
package extmem_pkg;

  localparam int WS_W   = 5;
  localparam int HOLD_W = 3;
  localparam int CNT_W  = $clog2((1 << WS_W) + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STROBE,
    ST_ACKWAIT,
    ST_HOLD,
    ST_DONE
  } seqState_t;

  typedef struct packed {
    logic latchReq;
    logic decWait;
    logic loadHold;
    logic decHold;
  } seqCtrl_t;

  function automatic logic [CNT_W-1:0] decodeWait(input logic [WS_W-1:0] code);
    logic [CNT_W-1:0] len;
    if (code == '0) len = CNT_W'(1 << WS_W);
    else            len = CNT_W'(code);
    return len;
  endfunction

endpackage

// File: rtl/extmem_dpath.sv
module extmem_dpath
  import extmem_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqCtrl_t            ctrl,
  input  logic [WS_W-1:0]     cfgWaitStates,
  input  logic [HOLD_W-1:0]   cfgHoldCycles,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   reqAddr,
  output logic [ADDR_W-1:0]   addrQ,
  output logic                writeQ,
  output logic                waitLast,
  output logic                holdLast,
  output logic                holdNone
);

  logic [CNT_W-1:0]  waitCnt;
  logic [HOLD_W-1:0] holdCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      writeQ  <= 1'b0;
      waitCnt <= '0;
    end else if (ctrl.latchReq) begin
      addrQ   <= reqAddr;
      writeQ  <= reqWrite;
      waitCnt <= decodeWait(cfgWaitStates);
    end else if (ctrl.decWait) begin
      waitCnt <= waitCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt <= '0;
    end else if (ctrl.loadHold) begin
      holdCnt <= cfgHoldCycles;
    end else if (ctrl.decHold) begin
      holdCnt <= holdCnt - 1'b1;
    end
  end

  assign waitLast = (waitCnt == CNT_W'(1));
  assign holdLast = (holdCnt == HOLD_W'(1));
  assign holdNone = (cfgHoldCycles == '0);

endmodule

// File: rtl/extmem_ctrl.sv
module extmem_ctrl
  import extmem_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cfgEnable,
  input  logic      cfgAckEnable,
  input  logic      reqValid,
  input  logic      ackIn,
  input  logic      writeQ,
  input  logic      waitLast,
  input  logic      holdLast,
  input  logic      holdNone,
  output seqCtrl_t  ctrl,
  output logic      reqReady,
  output logic      addrValid,
  output logic      rdStrobe,
  output logic      wrStrobe,
  output logic      dataEnable,
  output logic      donePulse
);

  seqState_t state, stateNext;
  logic      strobing;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    ctrl      = '0;
    unique case (state)
      ST_IDLE: begin
        if (cfgEnable && reqValid) begin
          ctrl.latchReq = 1'b1;
          stateNext     = ST_STROBE;
        end
      end
      ST_STROBE: begin
        if (!waitLast) begin
          ctrl.decWait = 1'b1;
        end else if (cfgAckEnable && !ackIn) begin
          stateNext = ST_ACKWAIT;
        end else if (writeQ && !holdNone) begin
          ctrl.loadHold = 1'b1;
          stateNext     = ST_HOLD;
        end else begin
          stateNext = ST_DONE;
        end
      end
      ST_ACKWAIT: begin
        if (ackIn) begin
          if (writeQ && !holdNone) begin
            ctrl.loadHold = 1'b1;
            stateNext     = ST_HOLD;
          end else begin
            stateNext = ST_DONE;
          end
        end
      end
      ST_HOLD: begin
        if (holdLast) stateNext = ST_DONE;
        else          ctrl.decHold = 1'b1;
      end
      ST_DONE:  stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  assign strobing   = (state == ST_STROBE) || (state == ST_ACKWAIT);
  assign reqReady   = (state == ST_IDLE) && cfgEnable;
  assign addrValid  = strobing || (state == ST_HOLD);
  assign rdStrobe   = strobing && !writeQ;
  assign wrStrobe   = strobing && writeQ;
  assign dataEnable = addrValid && writeQ;
  assign donePulse  = (state == ST_DONE);

endmodule

// File: rtl/extmem_seq.sv
module extmem_seq
  import extmem_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgEnable,
  input  logic [4:0]        cfgWaitStates,
  input  logic              cfgAckEnable,
  input  logic [2:0]        cfgHoldCycles,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              ackIn,
  output logic              reqReady,
  output logic [ADDR_W-1:0] busAddr,
  output logic              addrValid,
  output logic              rdStrobe,
  output logic              wrStrobe,
  output logic              dataEnable,
  output logic              donePulse
);

  seqCtrl_t ctrl;
  logic     writeQ;
  logic     waitLast;
  logic     holdLast;
  logic     holdNone;

  extmem_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cfgEnable    (cfgEnable),
    .cfgAckEnable (cfgAckEnable),
    .reqValid     (reqValid),
    .ackIn        (ackIn),
    .writeQ       (writeQ),
    .waitLast     (waitLast),
    .holdLast     (holdLast),
    .holdNone     (holdNone),
    .ctrl         (ctrl),
    .reqReady     (reqReady),
    .addrValid    (addrValid),
    .rdStrobe     (rdStrobe),
    .wrStrobe     (wrStrobe),
    .dataEnable   (dataEnable),
    .donePulse    (donePulse)
  );

  extmem_dpath #(.ADDR_W(ADDR_W)) u_dpath (
    .clk           (clk),
    .rstN          (rstN),
    .ctrl          (ctrl),
    .cfgWaitStates (cfgWaitStates),
    .cfgHoldCycles (cfgHoldCycles),
    .reqWrite      (reqWrite),
    .reqAddr       (reqAddr),
    .addrQ         (busAddr),
    .writeQ        (writeQ),
    .waitLast      (waitLast),
    .holdLast      (holdLast),
    .holdNone      (holdNone)
  );

endmodule

// File: rtl/extmem_seq_chk.sv
module extmem_seq_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgEnable,
  input logic [4:0]        cfgWaitStates,
  input logic              cfgAckEnable,
  input logic [2:0]        cfgHoldCycles,
  input logic              reqValid,
  input logic              reqWrite,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              ackIn,
  input logic              reqReady,
  input logic [ADDR_W-1:0] busAddr,
  input logic              addrValid,
  input logic              rdStrobe,
  input logic              wrStrobe,
  input logic              dataEnable,
  input logic              donePulse
);

  logic        anyStb;
  logic [15:0] stbCnt;
  logic [15:0] waitLen;

  assign anyStb  = rdStrobe || wrStrobe;
  assign waitLen = (cfgWaitStates == 5'd0) ? 16'd32 : {11'd0, cfgWaitStates};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       stbCnt <= '0;
    else if (anyStb) stbCnt <= (stbCnt == 16'hFFFF) ? stbCnt : stbCnt + 1'b1;
    else             stbCnt <= '0;
  end

  // R1
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgEnable && !addrValid && !donePulse) |=> !addrValid);

  // R2
  accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && reqValid) |=> (wrStrobe == $past(reqWrite)) && anyStb && (busAddr == $past(reqAddr)));

  // R2
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    addrValid |=> (!addrValid || $stable(busAddr)));

  // R2
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!addrValid && !donePulse));

  // R3
  strobe_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(anyStb) |-> (stbCnt >= waitLen));

  // R6
  ack_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(anyStb) && cfgAckEnable) |-> $past(ackIn));

  // R7
  write_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(wrStrobe) && (cfgHoldCycles != 3'd0)) |-> (addrValid && dataEnable));

  // R8
  read_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe |=> (rdStrobe || donePulse));

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> (!donePulse && !addrValid));

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(rdStrobe && wrStrobe) && !(rdStrobe && dataEnable));

endmodule

bind extmem_seq extmem_seq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/extmem_seq_tb.sv
`timescale 1ns/1ps
module extmem_seq_tb;

  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgEnable = 1'b0;
  logic [4:0]    cfgWaitStates = 5'd2;
  logic          cfgAckEnable = 1'b0;
  logic [2:0]    cfgHoldCycles = 3'd0;
  logic          reqValid = 1'b0;
  logic          reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic          ackIn = 1'b1;
  logic          reqReady;
  logic [AW-1:0] busAddr;
  logic          addrValid;
  logic          rdStrobe;
  logic          wrStrobe;
  logic          dataEnable;
  logic          donePulse;

  always #4 clk = ~clk;

  extmem_seq #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .cfgWaitStates(cfgWaitStates),
    .cfgAckEnable(cfgAckEnable), .cfgHoldCycles(cfgHoldCycles), .reqValid(reqValid),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .ackIn(ackIn), .reqReady(reqReady),
    .busAddr(busAddr), .addrValid(addrValid), .rdStrobe(rdStrobe), .wrStrobe(wrStrobe),
    .dataEnable(dataEnable), .donePulse(donePulse)
  );

  typedef struct {
    bit            wr;
    logic [AW-1:0] addr;
    int            stbLen;
    int            holdLen;
    string         tag;
  } expItem_t;

  expItem_t expQ[$];
  int nCompared = 0;
  int nMismatched = 0;
  bit summaryDone = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    nCompared++;
    if (!ok) begin
      nMismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic finishRun();
    if (!summaryDone) begin
      summaryDone = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
      $finish;
    end
  endtask

  // Monitor: measures each access at the ports and compares it with the queue head
  bit            inAcc = 1'b0;
  bit            curWr;
  logic [AW-1:0] curAddr;
  int            sLen;
  int            hLen;
  int            badCycles;

  always @(negedge clk) begin
    if (rstN) begin
      if (addrValid && !inAcc) begin
        inAcc = 1'b1; curAddr = busAddr; curWr = wrStrobe;
        sLen = 0; hLen = 0; badCycles = 0;
      end
      if (inAcc && !donePulse) begin
        if (rdStrobe || wrStrobe) sLen++;
        else if (addrValid) hLen++;
        else badCycles++;
        if (busAddr != curAddr || dataEnable != curWr || (rdStrobe && wrStrobe))
          badCycles++;
      end
      if (donePulse) begin
        if (!inAcc || expQ.size() == 0) begin
          check(1'b0, "R9 unexpected done", 1, 0);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          check(curAddr == e.addr, {e.tag, " R2 address"}, int'(curAddr), int'(e.addr));
          check(curWr == e.wr, {e.tag, " R2 direction"}, int'(curWr), int'(e.wr));
          check(sLen == e.stbLen, {e.tag, " strobe length"}, sLen, e.stbLen);
          check(hLen == e.holdLen, {e.tag, " hold length"}, hLen, e.holdLen);
          check(badCycles == 0 && !addrValid, {e.tag, " R9 R10 gaps/stability"}, badCycles, 0);
        end
        inAcc = 1'b0;
      end
    end
  end

  // Driver: one access, pushes its expected measurements
  task automatic doAccess(input bit wr, input logic [AW-1:0] a, input logic [4:0] ws,
                          input bit ackEn, input int ext, input logic [2:0] hold,
                          input bit poke, input string tag);
    expItem_t e;
    int n;
    int k;
    n = (ws == 5'd0) ? 32 : int'(ws);
    e.wr = wr; e.addr = a; e.stbLen = n + (ackEn ? ext : 0);
    e.holdLen = wr ? int'(hold) : 0; e.tag = tag;
    expQ.push_back(e);
    cfgWaitStates = ws; cfgAckEnable = ackEn; cfgHoldCycles = hold;
    reqWrite = wr; reqAddr = a; reqValid = 1'b1;
    ackIn = ackEn ? (ext == 0) : 1'b0;
    check(reqReady == 1'b1, {tag, " R2 ready when idle"}, int'(reqReady), 1);
    @(negedge clk);
    reqValid = poke;
    if (poke) begin reqAddr = ~a; reqWrite = ~wr; end
    k = 1;
    if (ackEn) begin
      while (k < n + ext) begin @(negedge clk); k++; end
      ackIn = 1'b1;
    end
    forever begin
      if (donePulse) break;
      if (poke) check(reqReady == 1'b0, {tag, " R2 busy not ready"}, int'(reqReady), 0);
      @(negedge clk);
    end
    reqValid = 1'b0;
    ackIn = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    check(1'b0, "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!addrValid && !rdStrobe && !wrStrobe && !donePulse && !reqReady,
          "reset state", int'(addrValid), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1: disabled, request held high
    reqValid = 1'b1; reqAddr = 24'h0000AA;
    for (int i = 0; i < 8; i++) begin
      check(!reqReady && !addrValid && !rdStrobe && !wrStrobe && !dataEnable,
            "R1 disabled", int'(addrValid | rdStrobe | wrStrobe), 0);
      @(negedge clk);
    end
    reqValid = 1'b0;
    cfgEnable = 1'b1;
    @(negedge clk);

    doAccess(1'b0, 24'h123456, 5'd2,  1'b0, 0, 3'd5, 1'b0, "R3 R8 read ws2");
    doAccess(1'b1, 24'h00BEEF, 5'd7,  1'b0, 0, 3'd0, 1'b0, "R3 R7 write ws7 nohold");
    doAccess(1'b0, 24'hABCDEF, 5'd31, 1'b0, 0, 3'd0, 1'b1, "R3 R2 read ws31 poke");
    doAccess(1'b1, 24'h5A5A5A, 5'd0,  1'b0, 0, 3'd1, 1'b0, "R4 write ws0");
    doAccess(1'b0, 24'h000001, 5'd1,  1'b0, 0, 3'd0, 1'b0, "R5 read ws1");
    doAccess(1'b1, 24'h000002, 5'd1,  1'b0, 0, 3'd2, 1'b0, "R5 R7 write ws1 hold2");
    doAccess(1'b1, 24'hC0FFEE, 5'd3,  1'b0, 0, 3'd7, 1'b1, "R7 R2 write hold7 poke");
    doAccess(1'b0, 24'h777777, 5'd4,  1'b1, 3, 3'd0, 1'b0, "R6 read ack ext3");
    doAccess(1'b1, 24'h888888, 5'd2,  1'b1, 0, 3'd3, 1'b0, "R6 write ack ready");
    doAccess(1'b1, 24'h999999, 5'd5,  1'b1, 4, 3'd2, 1'b0, "R6 R7 write ack ext4");
    doAccess(1'b0, 24'h101010, 5'd1,  1'b1, 2, 3'd0, 1'b0, "R6 R5 read ws1 ext2");
    doAccess(1'b0, 24'h202020, 5'd3,  1'b0, 0, 3'd0, 1'b0, "R6 ack ignored");

    // R9: idle and ready again after completion
    check(reqReady && !addrValid && !donePulse, "R9 idle after done", int'(reqReady), 1);
    check(expQ.size() == 0, "R9 all accesses completed", expQ.size(), 0);

    // R1: disabling again blocks new requests
    cfgEnable = 1'b0; reqValid = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(!addrValid && !reqReady, "R1 disabled after use", int'(addrValid), 0);
    end
    reqValid = 1'b0;
    finishRun();
  end

endmodule